// File: doc/BRIEF.md
# Dual-Bank LCD Shift-Latch Driver

This block is the digital core of a liquid-crystal row/column driver with two banks of 20 channels each. Every bank holds a serial shift register that can be loaded from either end, plus a parallel latch stage. For each channel the block emits a 2-bit drive-level code, not an analog voltage. The code picks the select or non-select level pair and, within that pair, the level that matches the current AC alternation phase.

Two strobe inputs, `strb_a_i` and `strb_b_i`, set the timing. Both are sampled on the system clock, and an action takes place on a strobe's falling edge. In the normal configuration both banks shift on strobe B and latch on strobe A. When `split_i` is high, the second bank swaps these roles and sees the alternation input inverted. The first bank can then serve as the segment driver while the second serves as the common driver. Each bank's far-end stage is driven onto whichever serial pin is not the input, so banks or devices can be cascaded.

Top module: `lcd_dual_bank_drv`

## Requirements
- R1: While `rst_ni` is low, every shift and latch bit is cleared. With `alt_i`=0 and `split_i`=0, `lvl_o` then reads all zero, which is non-select on every channel.
- R2: With `dir_i[b]`=0, bank b takes data from `ser_left_io[b]`. On each shift event the data moves from channel k to channel k+1, and the new bit enters channel 0. `ser_right_io[b]` drives the content of channel 19, and `ser_left_io[b]` is left at high impedance.
- R3: With `dir_i[b]`=1, bank b takes data from `ser_right_io[b]`. On each shift event the data moves from channel k to channel k-1, and the new bit enters channel 19. `ser_left_io[b]` drives the content of channel 0, and `ser_right_io[b]` is left at high impedance.
- R4: An event is a strobe that is 1 at one clock edge and 0 at the next. The register update happens at that second edge. A latch event copies all 20 shift bits of a bank into its latch at once. Shifting without a latch event leaves `lvl_o` unchanged.
- R5: With `split_i`=0, both banks shift on falling `strb_b_i`, latch on falling `strb_a_i`, and use `alt_i` as given.
- R6: With `split_i`=1, the first bank behaves as under R5. The second bank shifts on falling `strb_a_i`, latches on falling `strb_b_i`, and uses the inverse of `alt_i`.
- R7: Channel k of bank b (b=0 first, b=1 second) occupies `lvl_o[2*(20*b+k) +: 2]`. Bit 1 of that code is the latched data bit (1 = select). Bit 0 is the latched bit XOR the bank's effective alternation value. A change of `alt_i` shows on bit 0 with no latch event.
- R8: When a shift event and a latch event hit the same bank on the same clock edge, the latch captures the contents from before the shift.
- R9: With both directions at 0 and `ser_right_io[0]` wired to `ser_left_io[1]`, 40 shift events form one 40-stage chain. The first 20 bits shifted in end up in the second bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock on which the strobes are sampled |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strb_a_i | input | 1 | Strobe A: latch for both banks, or shift for the second bank in split mode |
| strb_b_i | input | 1 | Strobe B: shift for both banks, or latch for the second bank in split mode |
| split_i | input | 1 | Swaps the strobe roles and the alternation polarity of the second bank |
| alt_i | input | 1 | Frame alternation (AC polarity) input |
| dir_i | input | 2 | Per-bank entry side: 0 = enter left, 1 = enter right |
| ser_left_io | inout | 2 | Per-bank left serial pin: input or cascade output |
| ser_right_io | inout | 2 | Per-bank right serial pin: input or cascade output |
| lvl_o | output | 80 | Two-bit drive-level code per channel |

## Verification
The assertions assume that the strobes, `alt_i`, `split_i` and `dir_i` are synchronous to `clk_i`, and that each strobe pulse stays high for at least one full clock cycle. They also assume that the serial input pin carries a defined level whenever a shift event occurs. The stimulus meets these conditions by changing every input only on the falling clock edge. It holds each strobe high for one whole cycle before dropping it, and it drives the selected input pin, or the neighbouring cascade output, throughout every shift.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int NUM_BANKS = 2;
  localparam logic ENTER_RIGHT = 1'b1;

  typedef struct packed {
    logic shift;
    logic latch;
    logic alt;
  } bank_ctl_t;

  function automatic logic [1:0] lvl_code(input logic data, input logic alt);
    return {data, data ^ alt};
  endfunction
endpackage

// File: rtl/lcd_fall_det.sv
module lcd_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strb_i;
  end

  assign fall_o = prev_q & ~strb_i;
endmodule

// File: rtl/lcd_role_map.sv
module lcd_role_map
  import lcd_drv_pkg::*;
#(
  parameter bit SWAP_ENABLE = 1'b0
) (
  input  logic      fall_a_i,
  input  logic      fall_b_i,
  input  logic      split_i,
  input  logic      alt_i,
  output bank_ctl_t ctl_o
);
  if (SWAP_ENABLE) begin : g_swap
    always_comb begin
      ctl_o.shift = split_i ? fall_a_i : fall_b_i;
      ctl_o.latch = split_i ? fall_b_i : fall_a_i;
      ctl_o.alt   = alt_i ^ split_i;
    end
  end else begin : g_fixed
    logic unused_split;
    assign unused_split = split_i;
    always_comb begin
      ctl_o.shift = fall_b_i;
      ctl_o.latch = fall_a_i;
      ctl_o.alt   = alt_i;
    end
  end
endmodule

// File: rtl/lcd_shift_bank.sv
module lcd_shift_bank
  import lcd_drv_pkg::*;
#(
  parameter int CH = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  bank_ctl_t       ctl_i,
  input  logic            dir_i,
  input  logic            ser_in_i,
  output logic            far_o,
  output logic [2*CH-1:0] lvl_o
);
  logic [CH-1:0] sr_q;
  logic [CH-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      lat_q <= '0;
    end else begin
      if (ctl_i.shift) begin
        if (dir_i == ENTER_RIGHT) sr_q <= {ser_in_i, sr_q[CH-1:1]};
        else                      sr_q <= {sr_q[CH-2:0], ser_in_i};
      end
      if (ctl_i.latch) lat_q <= sr_q;  // pre-shift contents on a shared edge
    end
  end

  assign far_o = (dir_i == ENTER_RIGHT) ? sr_q[0] : sr_q[CH-1];

  for (genvar k = 0; k < CH; k++) begin : g_ch
    assign lvl_o[2*k +: 2] = lvl_code(lat_q[k], ctl_i.alt);
  end

  // R2
  shift_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.shift && dir_i != ENTER_RIGHT) |=>
      (sr_q[0] == $past(ser_in_i) && sr_q[CH-1:1] == $past(sr_q[CH-2:0])));

  // R3
  shift_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.shift && dir_i == ENTER_RIGHT) |=>
      (sr_q[CH-1] == $past(ser_in_i) && sr_q[CH-2:0] == $past(sr_q[CH-1:1])));

  // R2
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.shift |=> $stable(sr_q));

  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.latch |=> $stable(lat_q));

  // R8
  latch_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.latch |=> (lat_q == $past(sr_q)));
endmodule

// File: rtl/lcd_dual_bank_drv.sv
module lcd_dual_bank_drv
  import lcd_drv_pkg::*;
#(
  parameter int CH = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      strb_a_i,
  input  logic                      strb_b_i,
  input  logic                      split_i,
  input  logic                      alt_i,
  input  logic [NUM_BANKS-1:0]      dir_i,
  inout  wire  [NUM_BANKS-1:0]      ser_left_io,
  inout  wire  [NUM_BANKS-1:0]      ser_right_io,
  output logic [2*CH*NUM_BANKS-1:0] lvl_o
);
  localparam int BANK_W = 2 * CH;

  logic fall_a, fall_b;

  lcd_fall_det u_fall_a (.clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb_a_i), .fall_o(fall_a));
  lcd_fall_det u_fall_b (.clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb_b_i), .fall_o(fall_b));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_ctl_t ctl;
    logic      ser_in;
    logic      far;

    lcd_role_map #(.SWAP_ENABLE(g > 0)) u_role (
      .fall_a_i(fall_a),
      .fall_b_i(fall_b),
      .split_i (split_i),
      .alt_i   (alt_i),
      .ctl_o   (ctl)
    );

    assign ser_in = (dir_i[g] == ENTER_RIGHT) ? ser_right_io[g] : ser_left_io[g];

    lcd_shift_bank #(.CH(CH)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ctl_i   (ctl),
      .dir_i   (dir_i[g]),
      .ser_in_i(ser_in),
      .far_o   (far),
      .lvl_o   (lvl_o[g*BANK_W +: BANK_W])
    );

    assign ser_left_io[g]  = (dir_i[g] == ENTER_RIGHT) ? far  : 1'bz;
    assign ser_right_io[g] = (dir_i[g] == ENTER_RIGHT) ? 1'bz : far;
  end
endmodule

// File: tb/lcd_dual_bank_drv_tb.sv
module lcd_dual_bank_drv_tb_top;
  localparam int CH = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strb_a = 1'b0, strb_b = 1'b0, split = 1'b0, alt = 1'b0;
  logic [1:0] dir_q = 2'b00;
  logic [1:0] din = 2'b00;
  logic       chain = 1'b0;
  wire  [1:0] ser_left, ser_right;
  logic [79:0] lvl;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign ser_left[0]  = dir_q[0] ? 1'bz : din[0];
  assign ser_right[0] = dir_q[0] ? din[0] : 1'bz;
  assign ser_left[1]  = dir_q[1] ? 1'bz : (chain ? ser_right[0] : din[1]);
  assign ser_right[1] = dir_q[1] ? din[1] : 1'bz;

  lcd_dual_bank_drv #(.CH(CH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .strb_a_i(strb_a), .strb_b_i(strb_b),
    .split_i(split), .alt_i(alt), .dir_i(dir_q),
    .ser_left_io(ser_left), .ser_right_io(ser_right), .lvl_o(lvl)
  );

  // {split, alt, dir0, dir1, pattern bank0, pattern bank1}
  localparam logic [43:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 20'hA5C31, 20'h0F3E7},
    {1'b0, 1'b1, 1'b1, 1'b0, 20'h3C96A, 20'hE1D24},
    {1'b0, 1'b0, 1'b1, 1'b1, 20'h80001, 20'h7FFFE},
    {1'b1, 1'b0, 1'b0, 1'b0, 20'h5B2E9, 20'hC4470},
    {1'b1, 1'b1, 1'b1, 1'b0, 20'h12345, 20'hFEDC8},
    {1'b1, 1'b0, 1'b0, 1'b1, 20'hF0F0C, 20'h0137B}
  };

  function automatic logic [79:0] exp_lvl(input logic [19:0] p0, input logic [19:0] p1,
                                          input logic sp, input logic m);
    logic [79:0] r;
    for (int j = 0; j < CH; j++) begin
      r[2*j +: 2]        = {p0[j], p0[j] ^ m};
      r[2*(CH+j) +: 2]   = {p1[j], p1[j] ^ m ^ sp};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // starts and ends at a negedge; the action lands on the posedge before return
  task automatic pulse(input logic a, input logic b);
    strb_a = a; strb_b = b;
    @(negedge clk);
    strb_a = 1'b0; strb_b = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic feed_bit(input logic [19:0] p, input logic d, input int i);
    return d ? p[i] : p[19-i];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [79:0] hold;
    logic [39:0] dseq;
    logic [19:0] e0, e1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", lvl, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int e = 0; e < 6; e++) begin
      logic sp, m, d0, d1;
      logic [19:0] p0, p1;
      {sp, m, d0, d1, p0, p1} = VEC[e];
      split = sp; alt = m; dir_q = {d1, d0};
      if (!sp) begin
        for (int i = 0; i < CH; i++) begin
          din = {feed_bit(p1, d1, i), feed_bit(p0, d0, i)};
          pulse(1'b0, 1'b1);
        end
        chk(d0 ? "R3 cascade pin bank0" : "R2 cascade pin bank0",
            {79'b0, d0 ? ser_left[0] : ser_right[0]}, {79'b0, d0 ? p0[0] : p0[19]});
        pulse(1'b1, 1'b0);
        chk("R5 R2 R3 normal mode load", lvl, exp_lvl(p0, p1, sp, m));
      end else begin
        for (int i = 0; i < CH; i++) begin
          din = {feed_bit(p1, d1, i), 1'b0};
          pulse(1'b1, 1'b0);
        end
        for (int i = 0; i < CH; i++) begin
          din = {1'b0, feed_bit(p0, d0, i)};
          pulse(1'b0, 1'b1);
        end
        pulse(1'b1, 1'b0);
        chk("R6 R2 R3 split mode load", lvl, exp_lvl(p0, p1, sp, m));
      end
    end

    // R4 shifting alone leaves outputs unchanged; R8 shared edge latches pre-shift
    split = 1'b0; alt = 1'b0; dir_q = 2'b00;
    e0 = 20'h6A9D3; e1 = 20'hB2C15;
    for (int i = 0; i < CH; i++) begin
      din = {e1[19-i], e0[19-i]};
      pulse(1'b0, 1'b1);
    end
    pulse(1'b1, 1'b0);
    hold = lvl;
    chk("R4 latch after load", lvl, exp_lvl(e0, e1, 1'b0, 1'b0));
    for (int i = 0; i < CH; i++) begin
      din = {e0[19-i], e1[19-i]};
      pulse(1'b0, 1'b1);
    end
    chk("R4 shift without latch", lvl, hold);
    din = 2'b11;
    pulse(1'b1, 1'b1);
    chk("R8 shared edge", lvl, exp_lvl(e1, e0, 1'b0, 1'b0));

    // R7 alternation flips bit 0 without a latch event
    alt = 1'b1;
    @(negedge clk);
    chk("R7 alt toggle", lvl, exp_lvl(e1, e0, 1'b0, 1'b1));
    split = 1'b1;
    @(negedge clk);
    chk("R7 R6 split polarity", lvl, exp_lvl(e1, e0, 1'b1, 1'b1));

    // R9 cascade bank0 right pin into bank1 left pin
    split = 1'b0; alt = 1'b0; dir_q = 2'b00; chain = 1'b1;
    dseq = 40'hC3_5A96_E1F2;
    for (int k = 0; k < 40; k++) begin
      din = {1'b0, dseq[k]};
      pulse(1'b0, 1'b1);
    end
    pulse(1'b1, 1'b0);
    for (int j = 0; j < CH; j++) begin
      e1[j] = dseq[19-j];
      e0[j] = dseq[39-j];
    end
    chk("R9 cascade chain", lvl, exp_lvl(e0, e1, 1'b0, 1'b0));
    chain = 1'b0;

    // R1 reset in mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset clears latches", lvl, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    pulse(1'b1, 1'b0);
    chk("R1 shift cleared by reset", lvl, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule